// File: doc/BRIEF.md
# Transport stream packet framer

The framer takes a byte-wide transport stream that has already been brought into the local fast clock domain. Each incoming byte comes with a valid strobe and a packet-sync flag. The block finds the packet boundaries, locks onto them, and passes downstream only packets that are complete and correctly formed. Each forwarded packet is marked with a start-of-packet flag on its first byte and an end-of-packet flag on its last byte.

Alongside the packet output, the framer reports the state of the flow:
- a stop flag, asserted while no valid flow is present;
- a stable flag, which is always the inverse of stop;
- a one-cycle start pulse each time lock is regained;
- an indicator that says whether packets are 188 or 204 bytes long.

All timeouts count a reference tick input. They are independent of the incoming byte rate.

Internally there are three modes:
- Search mode hunts for alignment.
- Locked mode checks every packet against the latched length and watches for a stalled flow.
- Hold mode keeps stop asserted for a fixed number of ticks before a new search begins.

Packet bytes are written into a ring buffer. A packet is read out only once all of its bytes have arrived and been checked.

Top module: `ts_packet_framer`

## Requirements
- R1: A packet start is recognised only when the sync flag and a byte value of 0x47 arrive together. A flag on any other value, or 0x47 without the flag, is a framing error. In search mode it breaks the current run of good packets. In locked mode it forces hold mode.
- R2: A packet that is shorter than the expected length when the next sync arrives is never forwarded. In locked mode that early sync forces hold mode.
- R3: Lock is declared on the sync byte that closes the third consecutive well-formed packet of one length. A length change, or a malformed packet, restarts the count.
- R4: The length indicator reads 0 when the latched length is 188 bytes and 1 when it is 204 bytes.
- R5: After reset, stop is 1, stable is 0, start is 0 and no packet byte is output. Stable is always the inverse of stop.
- R6: Start is a single-cycle pulse, issued on every transition from stopped to locked.
- R7: In locked mode, each packet is forwarded unchanged and in order, beginning with the packet whose sync caused lock. Start-of-packet is on its 0x47 byte and end-of-packet on its final byte, and output begins only after the final byte has been received.
- R8: In locked mode, IDLE_TICKS reference ticks with no valid byte force hold mode and raise stop. Fewer ticks do not.
- R9: Hold mode lasts STOP_TICKS reference ticks and then returns to search mode. Stop stays asserted until lock is achieved again. Bytes received in hold mode produce no output and no start pulse.
- R10: In locked mode, a non-sync byte at the position where the next sync is due forces hold mode. The packet that ended just before that byte is still forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast local clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ts_data_i | input | 8 | Incoming stream byte |
| ts_valid_i | input | 1 | Byte strobe, one byte per asserted cycle |
| ts_sync_i | input | 1 | Packet-sync flag for the current byte |
| ref_tick_i | input | 1 | Single-cycle reference tick for timeouts |
| pkt_data_o | output | 8 | Forwarded packet byte |
| pkt_valid_o | output | 1 | Forwarded byte valid |
| pkt_sop_o | output | 1 | First byte of a forwarded packet |
| pkt_eop_o | output | 1 | Last byte of a forwarded packet |
| flow_stop_o | output | 1 | No valid flow |
| flow_stable_o | output | 1 | Inverse of flow_stop_o |
| flow_start_o | output | 1 | One-cycle pulse on regaining lock |
| pkt_len204_o | output | 1 | 0 = 188-byte packets, 1 = 204-byte packets |

## Verification
Clean streams of 188-byte and 204-byte packets show that lock comes on the fourth sync, that the length flag is set correctly, and that forwarded data is intact. A stream whose length changes partway through a run shows that the good-packet counter restarts instead of mixing lengths.

Two kinds of corrupted sync are tried in search mode: a flag on a wrong value, and 0x47 without the flag. Together they separate a check that requires both conditions from one that accepts either.

In locked mode, three disruptions are applied:
- a short packet, which must be discarded;
- an over-long packet, where the packet closed at the expected length is kept;
- a silent gap, followed by bytes sent during hold mode and then a relock.

Between them these show what is dropped, what is kept, and when stop and start move.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  typedef enum logic [1:0] {
    MODE_SEARCH = 2'd0,
    MODE_LOCKED = 2'd1,
    MODE_HOLD   = 2'd2
  } mode_e;

  localparam logic [7:0] SYNC_VAL  = 8'h47;
  localparam int         LEN_SHORT = 188;
  localparam int         LEN_LONG  = 204;
  localparam int         CNT_W     = 8;
endpackage

// File: rtl/tsf_byte_check.sv
module tsf_byte_check (
  input  logic [7:0] data_i,
  input  logic       valid_i,
  input  logic       sync_i,
  output logic       sync_ok_o,
  output logic       frame_err_o
);
  import tsf_pkg::*;

  logic is_sync_val;

  always_comb begin
    is_sync_val = (data_i == SYNC_VAL);
    sync_ok_o   = valid_i & sync_i & is_sync_val;
    frame_err_o = valid_i & (sync_i ^ is_sync_val);
  end
endmodule

// File: rtl/tsf_lock_fsm.sv
module tsf_lock_fsm #(
  parameter int LOCK_PKTS  = 3,
  parameter int IDLE_TICKS = 1000,
  parameter int STOP_TICKS = 1000
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic                      sync_ok_i,
  input  logic                      frame_err_i,
  input  logic                      tick_i,
  output logic                      pkt_done_o,
  output logic                      len204_o,
  output logic                      stop_o,
  output logic                      start_o
);
  import tsf_pkg::*;

  localparam int TICK_MAX = (IDLE_TICKS > STOP_TICKS) ? IDLE_TICKS : STOP_TICKS;
  localparam int TICK_W   = $clog2(TICK_MAX + 1);
  localparam int RUN_W    = $clog2(LOCK_PKTS + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  mode_e             mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              in_pkt_q, err_q;
  logic [RUN_W-1:0]  run_q, run_next;
  logic              run_long_q;
  logic [TICK_W-1:0] tick_q;
  logic [CNT_W-1:0]  exp_len;
  logic              close_ok, close_long, lock_now;

  always_comb begin
    close_long = (cnt_q == CNT_W'(LEN_LONG));
    close_ok   = close_long || (cnt_q == CNT_W'(LEN_SHORT));
    if (in_pkt_q && !err_q && close_ok)
      run_next = (run_q != '0 && close_long == run_long_q) ? run_q + RUN_W'(1) : RUN_W'(1);
    else
      run_next = '0;
    lock_now = sync_ok_i && (run_next == RUN_W'(LOCK_PKTS));
    exp_len  = len204_o ? CNT_W'(LEN_LONG) : CNT_W'(LEN_SHORT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_SEARCH;
      cnt_q      <= '0;
      in_pkt_q   <= 1'b0;
      err_q      <= 1'b0;
      run_q      <= '0;
      run_long_q <= 1'b0;
      tick_q     <= '0;
      len204_o   <= 1'b0;
      stop_o     <= 1'b1;
      start_o    <= 1'b0;
      pkt_done_o <= 1'b0;
    end else begin
      start_o    <= 1'b0;
      pkt_done_o <= 1'b0;
      case (mode_q)
        MODE_SEARCH: begin
          if (sync_ok_i) begin
            cnt_q      <= CNT_W'(1);
            in_pkt_q   <= 1'b1;
            err_q      <= 1'b0;
            run_q      <= lock_now ? '0 : run_next;
            run_long_q <= close_long;
            if (lock_now) begin
              mode_q   <= MODE_LOCKED;
              len204_o <= close_long;
              stop_o   <= 1'b0;
              start_o  <= 1'b1;
              tick_q   <= '0;
            end
          end else if (valid_i) begin
            if (frame_err_i) err_q <= 1'b1;
            if (cnt_q != CNT_SAT) cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        MODE_LOCKED: begin
          if (valid_i) begin
            tick_q <= '0;
            if (frame_err_i || (sync_ok_i && cnt_q != exp_len) ||
                (!sync_ok_i && cnt_q == exp_len)) begin
              mode_q <= MODE_HOLD;
              stop_o <= 1'b1;
            end else if (sync_ok_i) begin
              cnt_q <= CNT_W'(1);
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
              if (cnt_q + CNT_W'(1) == exp_len) pkt_done_o <= 1'b1;
            end
          end else if (tick_i) begin
            if (tick_q == TICK_W'(IDLE_TICKS - 1)) begin
              mode_q <= MODE_HOLD;
              stop_o <= 1'b1;
              tick_q <= '0;
            end else begin
              tick_q <= tick_q + TICK_W'(1);
            end
          end
        end
        MODE_HOLD: begin
          if (tick_i) begin
            if (tick_q == TICK_W'(STOP_TICKS - 1)) begin
              mode_q   <= MODE_SEARCH;
              tick_q   <= '0;
              cnt_q    <= '0;
              in_pkt_q <= 1'b0;
              err_q    <= 1'b0;
              run_q    <= '0;
            end else begin
              tick_q <= tick_q + TICK_W'(1);
            end
          end
        end
        default: mode_q <= MODE_SEARCH;
      endcase
    end
  end

  // R1
  locked_err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_LOCKED && frame_err_i) |=> (mode_q == MODE_HOLD && stop_o));

  // R6
  start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  // R6
  start_from_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (!stop_o && $past(stop_o)));

  // R9
  unlocked_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_LOCKED) |-> stop_o);
endmodule

// File: rtl/tsf_pkt_buf.sv
module tsf_pkt_buf #(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  input  logic             base_mark_i,
  input  logic             done_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [7:0]       data_o,
  output logic             valid_o,
  output logic             sop_o,
  output logic             eop_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr_q, base_q, rd_ptr_q;
  logic [LEN_W-1:0]  rd_left_q;
  logic              first_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q  <= '0;
      base_q    <= '0;
      rd_ptr_q  <= '0;
      rd_left_q <= '0;
      first_q   <= 1'b0;
      data_o    <= '0;
      valid_o   <= 1'b0;
      sop_o     <= 1'b0;
      eop_o     <= 1'b0;
    end else begin
      if (wr_en_i) begin
        wr_ptr_q <= wr_ptr_q + ADDR_W'(1);
        if (base_mark_i) base_q <= wr_ptr_q;
      end
      valid_o <= 1'b0;
      sop_o   <= 1'b0;
      eop_o   <= 1'b0;
      if (rd_left_q != '0) begin
        data_o    <= mem[rd_ptr_q];
        valid_o   <= 1'b1;
        sop_o     <= first_q;
        eop_o     <= (rd_left_q == LEN_W'(1));
        rd_ptr_q  <= rd_ptr_q + ADDR_W'(1);
        rd_left_q <= rd_left_q - LEN_W'(1);
        first_q   <= 1'b0;
      end
      // a new packet may complete on the cycle the previous one drains
      if (done_i) begin
        rd_ptr_q  <= base_q;
        rd_left_q <= len_i;
        first_q   <= 1'b1;
      end
    end
  end

  // R7
  sop_eop_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sop_o || eop_o) |-> valid_o);

  // R7
  readout_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (rd_left_q < LEN_W'(2)));
endmodule

// File: rtl/ts_packet_framer.sv
module ts_packet_framer #(
  parameter int LOCK_PKTS  = 3,
  parameter int IDLE_TICKS = 1000,
  parameter int STOP_TICKS = 1000,
  parameter int BUF_AW     = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] ts_data_i,
  input  logic       ts_valid_i,
  input  logic       ts_sync_i,
  input  logic       ref_tick_i,
  output logic [7:0] pkt_data_o,
  output logic       pkt_valid_o,
  output logic       pkt_sop_o,
  output logic       pkt_eop_o,
  output logic       flow_stop_o,
  output logic       flow_stable_o,
  output logic       flow_start_o,
  output logic       pkt_len204_o
);
  import tsf_pkg::*;

  logic             sync_ok, frame_err, pkt_done;
  logic [CNT_W-1:0] pkt_len;

  tsf_byte_check u_byte_check (
    .data_i      (ts_data_i),
    .valid_i     (ts_valid_i),
    .sync_i      (ts_sync_i),
    .sync_ok_o   (sync_ok),
    .frame_err_o (frame_err)
  );

  tsf_lock_fsm #(
    .LOCK_PKTS  (LOCK_PKTS),
    .IDLE_TICKS (IDLE_TICKS),
    .STOP_TICKS (STOP_TICKS)
  ) u_lock_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (ts_valid_i),
    .sync_ok_i   (sync_ok),
    .frame_err_i (frame_err),
    .tick_i      (ref_tick_i),
    .pkt_done_o  (pkt_done),
    .len204_o    (pkt_len204_o),
    .stop_o      (flow_stop_o),
    .start_o     (flow_start_o)
  );

  assign pkt_len       = pkt_len204_o ? CNT_W'(LEN_LONG) : CNT_W'(LEN_SHORT);
  assign flow_stable_o = ~flow_stop_o;

  tsf_pkt_buf #(
    .ADDR_W (BUF_AW),
    .LEN_W  (CNT_W)
  ) u_pkt_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (ts_valid_i),
    .wr_data_i   (ts_data_i),
    .base_mark_i (sync_ok),
    .done_i      (pkt_done),
    .len_i       (pkt_len),
    .data_o      (pkt_data_o),
    .valid_o     (pkt_valid_o),
    .sop_o       (pkt_sop_o),
    .eop_o       (pkt_eop_o)
  );

  // R5
  stable_vs_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flow_stable_o != flow_stop_o);
endmodule

// File: tb/ts_packet_framer_bench.sv
module ts_packet_framer_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] ts_data_i = '0;
  logic       ts_valid_i = 1'b0;
  logic       ts_sync_i = 1'b0;
  logic       ref_tick_i = 1'b0;
  logic [7:0] pkt_data_o;
  logic       pkt_valid_o, pkt_sop_o, pkt_eop_o;
  logic       flow_stop_o, flow_stable_o, flow_start_o, pkt_len204_o;

  int n_chk = 0, n_fail = 0;
  int cap_n, sop_n, eop_n, start_n;
  logic [7:0] cap [2048];
  logic [7:0] expd [2048];
  logic       cap_sop0;
  int exp_n;
  int tdiv;

  always #5 clk_i = ~clk_i;

  ts_packet_framer #(
    .LOCK_PKTS (3), .IDLE_TICKS (20), .STOP_TICKS (10), .BUF_AW (8)
  ) u_ts_packet_framer (
    .clk_i (clk_i), .rst_ni (rst_ni), .ts_data_i (ts_data_i),
    .ts_valid_i (ts_valid_i), .ts_sync_i (ts_sync_i), .ref_tick_i (ref_tick_i),
    .pkt_data_o (pkt_data_o), .pkt_valid_o (pkt_valid_o), .pkt_sop_o (pkt_sop_o),
    .pkt_eop_o (pkt_eop_o), .flow_stop_o (flow_stop_o), .flow_stable_o (flow_stable_o),
    .flow_start_o (flow_start_o), .pkt_len204_o (pkt_len204_o)
  );

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      tdiv = 0; ref_tick_i = 1'b0;
    end else begin
      tdiv = (tdiv + 1) % 4;
      ref_tick_i = (tdiv == 0);
    end
  end

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      cap_n = 0; sop_n = 0; eop_n = 0; start_n = 0; cap_sop0 = 1'b0;
    end else begin
      if (pkt_valid_o) begin
        if (cap_n == 0) cap_sop0 = pkt_sop_o;
        if (cap_n < 2048) cap[cap_n] = pkt_data_o;
        cap_n++;
        if (pkt_sop_o) sop_n++;
        if (pkt_eop_o) eop_n++;
      end
      if (flow_start_o) start_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(input int seed, input int i);
    logic [7:0] b;
    b = 8'((seed * 31 + i * 5) & 255);
    if (b == 8'h47) b = 8'h48;
    return b;
  endfunction

  task automatic send_byte(input logic [7:0] d, input logic s);
    @(negedge clk_i);
    ts_data_i = d; ts_sync_i = s; ts_valid_i = 1'b1;
  endtask

  task automatic gap();
    @(negedge clk_i);
    ts_valid_i = 1'b0; ts_sync_i = 1'b0;
  endtask

  // bad: 0 good, 1 flag on 0x46, 2 0x47 without flag; fwd: bytes expected at output
  task automatic send_pkt(input int len, input int seed, input int bad, input int fwd);
    for (int i = 0; i < len; i++) begin
      logic [7:0] d;
      logic s;
      if (i == 0) begin
        d = (bad == 1) ? 8'h46 : 8'h47;
        s = (bad != 2);
      end else begin
        d = gen(seed, i); s = 1'b0;
      end
      send_byte(d, s);
      if (i < fwd) begin expd[exp_n] = d; exp_n++; end
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; ts_valid_i = 1'b0; ts_sync_i = 1'b0; exp_n = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic cmp_stream(input string req, input int pkts);
    int bad = 0;
    chk(cap_n == exp_n, req, cap_n, exp_n);
    chk(sop_n == pkts, req, sop_n, pkts);
    chk(eop_n == pkts, req, eop_n, pkts);
    for (int i = 0; i < exp_n && i < cap_n; i++)
      if (cap[i] !== expd[i]) bad++;
    chk(bad == 0, req, bad, 0);
    if (exp_n > 0) begin
      chk(cap_sop0 == 1'b1, req, int'(cap_sop0), 1);
      chk(cap[0] == 8'h47, req, int'(cap[0]), 'h47);
    end
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk_i);
    chk(flow_stop_o == 1'b1, "R5 stop", int'(flow_stop_o), 1);
    chk(flow_stable_o == 1'b0, "R5 stable", int'(flow_stable_o), 0);
    chk(flow_start_o == 1'b0, "R5 start", int'(flow_start_o), 0);
    chk(pkt_valid_o == 1'b0, "R5 valid", int'(pkt_valid_o), 0);
    chk(pkt_len204_o == 1'b0, "R5 len", int'(pkt_len204_o), 0);
  endtask

  task automatic t_lock(input int len, input bit long);
    do_reset();
    for (int p = 1; p <= 3; p++) send_pkt(len, p, 0, 0);
    gap();
    chk(flow_stop_o == 1'b1, "R3 no early lock", int'(flow_stop_o), 1);
    for (int p = 4; p <= 6; p++) send_pkt(len, p, 0, len);
    gap();
    chk(flow_stop_o == 1'b0, "R3 locked", int'(flow_stop_o), 0);
    chk(flow_stable_o == 1'b1, "R5 stable", int'(flow_stable_o), 1);
    chk(start_n == 1, "R6 one start", start_n, 1);
    chk(pkt_len204_o == long, "R4 length", int'(pkt_len204_o), int'(long));
    repeat (600) @(negedge clk_i);
    cmp_stream("R7 forward", 3);
    chk(flow_stop_o == 1'b1, "R8 idle stop", int'(flow_stop_o), 1);
  endtask

  task automatic t_mixed();
    do_reset();
    send_pkt(188, 1, 0, 0); send_pkt(188, 2, 0, 0);
    send_pkt(204, 3, 0, 0); send_pkt(204, 4, 0, 0); send_pkt(204, 5, 0, 0);
    gap();
    chk(flow_stop_o == 1'b1, "R3 mixed run", int'(flow_stop_o), 1);
    send_pkt(204, 6, 0, 204);
    gap();
    chk(flow_stop_o == 1'b0, "R3 mixed lock", int'(flow_stop_o), 0);
    chk(pkt_len204_o == 1'b1, "R4 long", int'(pkt_len204_o), 1);
    repeat (400) @(negedge clk_i);
    cmp_stream("R3 mixed fwd", 1);
  endtask

  task automatic t_bad_sync(input int mode);
    do_reset();
    send_pkt(188, 1, 0, 0); send_pkt(188, 2, mode, 0);
    for (int p = 3; p <= 5; p++) send_pkt(188, p, 0, 0);
    gap();
    chk(flow_stop_o == 1'b1, "R1 bad sync breaks run", int'(flow_stop_o), 1);
    send_pkt(188, 6, 0, 188);
    gap();
    chk(flow_stop_o == 1'b0, "R1 relock after bad", int'(flow_stop_o), 0);
    repeat (400) @(negedge clk_i);
    cmp_stream("R1 fwd", 1);
  endtask

  task automatic t_short();
    do_reset();
    for (int p = 1; p <= 3; p++) send_pkt(188, p, 0, 0);
    send_pkt(188, 4, 0, 188);
    send_pkt(100, 5, 0, 0);
    send_byte(8'h47, 1'b1);
    gap();
    chk(flow_stop_o == 1'b1, "R2 short stops", int'(flow_stop_o), 1);
    repeat (400) @(negedge clk_i);
    cmp_stream("R2 short dropped", 1);
  endtask

  task automatic t_mismatch();
    do_reset();
    for (int p = 1; p <= 3; p++) send_pkt(188, p, 0, 0);
    send_pkt(188, 4, 0, 188);
    send_pkt(204, 5, 0, 188);
    gap();
    chk(flow_stop_o == 1'b1, "R10 long stops", int'(flow_stop_o), 1);
    repeat (400) @(negedge clk_i);
    cmp_stream("R10 fwd", 2);
  endtask

  task automatic t_idle_restart();
    do_reset();
    for (int p = 1; p <= 3; p++) send_pkt(188, p, 0, 0);
    send_pkt(188, 4, 0, 188);
    gap();
    repeat (40) @(negedge clk_i);
    chk(flow_stop_o == 1'b0, "R8 not early", int'(flow_stop_o), 0);
    repeat (60) @(negedge clk_i);
    chk(flow_stop_o == 1'b1, "R8 timeout", int'(flow_stop_o), 1);
    for (int i = 1; i <= 10; i++) send_byte(gen(9, i), 1'b0);
    gap();
    chk(flow_stop_o == 1'b1, "R9 hold", int'(flow_stop_o), 1);
    chk(sop_n == 1, "R9 hold ignored", sop_n, 1);
    chk(start_n == 1, "R9 no start in hold", start_n, 1);
    repeat (80) @(negedge clk_i);
    chk(flow_stop_o == 1'b1, "R9 stop until relock", int'(flow_stop_o), 1);
    for (int p = 11; p <= 13; p++) send_pkt(188, p, 0, 0);
    send_pkt(188, 14, 0, 188);
    send_pkt(188, 15, 0, 188);
    gap();
    chk(flow_stop_o == 1'b0, "R9 relocked", int'(flow_stop_o), 0);
    chk(start_n == 2, "R6 second start", start_n, 2);
    repeat (400) @(negedge clk_i);
    cmp_stream("R7 after relock", 3);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_lock(188, 1'b0);
        t_lock(204, 1'b1);
        t_mixed();
        t_bad_sync(1);
        t_bad_sync(2);
        t_short();
        t_mismatch();
        t_idle_restart();
      end
      begin
        repeat (150000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule